// File: doc/BRIEF.md
# Frequency Acquisition Supervisor

This block sequences frequency acquisition for a clock-recovery loop. While the coarse frequency loop is in charge, it drives an oscillator sweep word upward from the bottom of its range, one step per sweep strobe. When the measured frequency error comes within the handover window, it passes control to the fine phase loop. If the sweep reaches the top without lock, the block parks. It starts again from the bottom only after a dead-band timer, counted from the start of the attempt, has run out.

In lock, a large error seen while the input toggles starts a new attempt. The restart waits for the dead band if that timer is still running. A quiet input (no transitions) never raises loss of lock. The block instead drops into a holdover state, and leaves that state immediately when activity returns, without regard to the dead band.

The dead band is normally long. A short dead band is chosen only when a control bit is set and a separate key register holds one exact value. Both registers keep their contents through a soft reset and return to their defaults only on power-on reset.

Top module: `facq_supervisor`

## Requirements
- R1: Each state has fixed flags: sweeping and dead-band waiting give lol_o=1 and handover_o=0, phase tracking gives lol_o=0 and handover_o=1, and holdover gives lol_o=0 and handover_o=0. The two flags are never high together.
- R2: While sweeping with activity_i high, a two's-complement ferr_i whose magnitude is at most LOCK_PPM (250) moves the block to phase tracking at the next edge. A magnitude of 251 does not.
- R3: Every attempt starts with sweep_o at 0. Within an attempt sweep_o only rises, by exactly 1 per accepted strobe, and it stops at its all-ones maximum.
- R4: If sweep_o reaches its maximum without lock, the block waits in the dead band with sweep_o held. After expiry it restarts from 0, and this repeats while lock is not reached. The restart period is max(dead band, max sweep + 1) + 1 clock cycles when step_i and tick_i are held high.
- R5: The dead band is counted in tick_i pulses from the edge that starts an attempt. After power-on its length is DB_LONG_TICKS.
- R6: In phase tracking with activity_i high, an error magnitude of at most RELOCK_PPM (1000) keeps lol_o low.
- R7: In phase tracking with activity_i high, an error magnitude above RELOCK_PPM raises lol_o at the next edge. The restart from sweep 0 happens at once if the dead band has expired. Otherwise sweep_o holds until expiry, and the restart follows.
- R8: In phase tracking, activity_i low moves the block to holdover. With no activity, lol_o stays low whatever ferr_i shows.
- R9: In holdover, returning activity with magnitude above RELOCK_PPM restarts the sweep from 0 at the next edge even while the dead band runs. Returning activity with a smaller magnitude resumes phase tracking.
- R10: A write sets control register address 0 and key register address 1. The short dead band (DB_SHORT_TICKS) is used for an attempt only when bit 7 of address 0 is 1 and address 1 equals 8'h40 exactly. Any other contents select the long dead band.
- R11: The configuration registers keep their values through soft_rst_i and clear to zero only on por_n low.
- R12: soft_rst_i starts a new attempt at the next edge from any state: sweep_o=0, lol_o=1, and a freshly loaded dead band.
- R13: With step_i low, sweep_o does not change except through a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including configuration |
| soft_rst_i | input | 1 | Synchronous soft reset; restarts acquisition, keeps configuration |
| tick_i | input | 1 | Prescaled dead-band timer tick |
| step_i | input | 1 | Sweep advance strobe |
| activity_i | input | 1 | High when the input shows transitions |
| ferr_i | input | ERR_W | Frequency error in ppm, two's complement |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | CFG_AW | Configuration register address |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| lol_o | output | 1 | Loss of lock, high while the coarse loop holds control |
| handover_o | output | 1 | High while the phase loop tracks |
| sweep_o | output | SWEEP_W | Oscillator sweep control word |

## Verification
The checker assumes that ferr_i is a settled two's-complement value at each edge and that activity_i is a level, not a pulse. Its relock and hold properties are therefore stated only for cycles with no soft reset. The bench changes every input just after a falling edge and holds it for whole cycles. It drives soft_rst_i as single-cycle pulses. It uses error values only up to ±30000, which keeps the magnitude inside the error width, and it holds step_i and tick_i high except in the test that freezes the sweep.

// File: rtl/facq_pkg.sv
package facq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE_LOCKED = 2'd0,
      ST_SWEEP       = 2'd1,
      ST_DB_WAIT     = 2'd2,
      ST_PHASE_TRACK = 2'd3
   } facq_state_e;

   typedef struct packed {
      logic lol;
      logic handover;
   } facq_flags_t;

   localparam int CTRL_IDX  = 0;
   localparam int KEY_IDX   = 1;
   localparam int SHORT_BIT = 7;
   localparam logic [7:0] KEY_VALUE = 8'h40;

   function automatic facq_flags_t state_flags(input facq_state_e s);
      facq_flags_t f;
      case (s)
         ST_SWEEP:       f = '{lol: 1'b1, handover: 1'b0};
         ST_DB_WAIT:     f = '{lol: 1'b1, handover: 1'b0};
         ST_PHASE_TRACK: f = '{lol: 1'b0, handover: 1'b1};
         default:        f = '{lol: 1'b0, handover: 1'b0};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/facq_cfg_regs.sv
module facq_cfg_regs #(
   parameter int CFG_AW = 1,
   parameter int CFG_DW = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              we_i,
   input  logic [CFG_AW-1:0] addr_i,
   input  logic [CFG_DW-1:0] wdata_i,
   output logic              short_sel_o
);
   import facq_pkg::*;

   localparam int NREG = 2;

   if ((1 << CFG_AW) < NREG) begin : g_bad_aw
      $error("facq_cfg_regs: CFG_AW too small for register count");
   end
   if (CFG_DW < 8) begin : g_bad_dw
      $error("facq_cfg_regs: CFG_DW must be at least 8");
   end

   logic [NREG-1:0][CFG_DW-1:0] reg_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [CFG_DW-1:0] q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            q <= '0;
         else if (we_i && (addr_i == CFG_AW'(i)))
            q <= wdata_i;
      end
      assign reg_q[i] = q;
   end

   assign short_sel_o = reg_q[CTRL_IDX][SHORT_BIT] &&
                        (reg_q[KEY_IDX] == CFG_DW'(KEY_VALUE));

endmodule

// File: rtl/facq_err_cmp.sv
module facq_err_cmp #(
   parameter int ERR_W      = 16,
   parameter int LOCK_PPM   = 250,
   parameter int RELOCK_PPM = 1000,
   parameter bit SIGNED_ERR = 1'b1
) (
   input  logic [ERR_W-1:0] ferr_i,
   output logic             within_lock_o,
   output logic             beyond_relock_o
);
   localparam int MW = ERR_W + 1;

   if (LOCK_PPM >= RELOCK_PPM) begin : g_bad_thr
      $error("facq_err_cmp: LOCK_PPM must be below RELOCK_PPM");
   end

   logic [MW-1:0] mag;

   if (SIGNED_ERR) begin : g_signed
      always_comb begin
         if (ferr_i[ERR_W-1])
            mag = {1'b0, ~ferr_i} + MW'(1);
         else
            mag = {1'b0, ferr_i};
      end
   end else begin : g_unsigned
      assign mag = {1'b0, ferr_i};
   end

   assign within_lock_o   = (mag <= MW'(LOCK_PPM));
   assign beyond_relock_o = (mag >  MW'(RELOCK_PPM));

endmodule

// File: rtl/facq_deadband.sv
module facq_deadband #(
   parameter int DB_LONG_TICKS  = 300,
   parameter int DB_SHORT_TICKS = 30
) (
   input  logic clk,
   input  logic por_n,
   input  logic load_i,
   input  logic short_sel_i,
   input  logic tick_i,
   output logic expired_o
);
   localparam int CW = $clog2(DB_LONG_TICKS + 1);

   if (DB_SHORT_TICKS >= DB_LONG_TICKS || DB_SHORT_TICKS < 1) begin : g_bad_db
      $error("facq_deadband: need 1 <= DB_SHORT_TICKS < DB_LONG_TICKS");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt_q <= CW'(DB_LONG_TICKS);
      else if (load_i)
         cnt_q <= short_sel_i ? CW'(DB_SHORT_TICKS) : CW'(DB_LONG_TICKS);
      else if (tick_i && (cnt_q != '0))
         cnt_q <= cnt_q - CW'(1);
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/facq_sweep.sv
module facq_sweep #(
   parameter int SWEEP_W = 12
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               clr_i,
   input  logic               adv_i,
   output logic [SWEEP_W-1:0] value_o,
   output logic               at_top_o
);
   if (SWEEP_W < 2) begin : g_bad_w
      $error("facq_sweep: SWEEP_W must be at least 2");
   end

   logic [SWEEP_W-1:0] val_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         val_q <= '0;
      else if (clr_i)
         val_q <= '0;
      else if (adv_i && !at_top_o)
         val_q <= val_q + SWEEP_W'(1);
   end

   assign at_top_o = &val_q;
   assign value_o  = val_q;

endmodule

// File: rtl/facq_supervisor.sv
module facq_supervisor #(
   parameter int ERR_W          = 16,
   parameter int SWEEP_W        = 12,
   parameter int LOCK_PPM       = 250,
   parameter int RELOCK_PPM     = 1000,
   parameter int DB_LONG_TICKS  = 300,
   parameter int DB_SHORT_TICKS = 30,
   parameter int CFG_AW         = 1,
   parameter int CFG_DW         = 8,
   parameter bit SIGNED_ERR     = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               soft_rst_i,
   input  logic               tick_i,
   input  logic               step_i,
   input  logic               activity_i,
   input  logic [ERR_W-1:0]   ferr_i,
   input  logic               cfg_we_i,
   input  logic [CFG_AW-1:0]  cfg_addr_i,
   input  logic [CFG_DW-1:0]  cfg_wdata_i,
   output logic               lol_o,
   output logic               handover_o,
   output logic [SWEEP_W-1:0] sweep_o
);
   import facq_pkg::*;

   if (ERR_W < 12) begin : g_bad_err
      $error("facq_supervisor: ERR_W too narrow for thresholds");
   end

   logic        short_sel, within_lock, beyond_relock, db_expired, at_top;
   logic        acq_start, sweep_adv;
   facq_state_e state_q, state_d;
   facq_flags_t flags;

   facq_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_cfg (
      .clk(clk), .por_n(por_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
      .wdata_i(cfg_wdata_i), .short_sel_o(short_sel)
   );

   facq_err_cmp #(.ERR_W(ERR_W), .LOCK_PPM(LOCK_PPM), .RELOCK_PPM(RELOCK_PPM),
                  .SIGNED_ERR(SIGNED_ERR)) u_cmp (
      .ferr_i(ferr_i), .within_lock_o(within_lock), .beyond_relock_o(beyond_relock)
   );

   facq_deadband #(.DB_LONG_TICKS(DB_LONG_TICKS), .DB_SHORT_TICKS(DB_SHORT_TICKS)) u_db (
      .clk(clk), .por_n(por_n), .load_i(acq_start), .short_sel_i(short_sel),
      .tick_i(tick_i), .expired_o(db_expired)
   );

   facq_sweep #(.SWEEP_W(SWEEP_W)) u_sweep (
      .clk(clk), .por_n(por_n), .clr_i(acq_start), .adv_i(sweep_adv),
      .value_o(sweep_o), .at_top_o(at_top)
   );

   always_comb begin
      state_d   = state_q;
      acq_start = 1'b0;
      if (soft_rst_i) begin
         state_d   = ST_SWEEP;
         acq_start = 1'b1;
      end else begin
         case (state_q)
            ST_SWEEP: begin
               if (activity_i && within_lock)
                  state_d = ST_PHASE_TRACK;
               else if (at_top)
                  state_d = ST_DB_WAIT;
            end
            ST_DB_WAIT: begin
               if (db_expired) begin
                  state_d   = ST_SWEEP;
                  acq_start = 1'b1;
               end
            end
            ST_PHASE_TRACK: begin
               if (!activity_i)
                  state_d = ST_IDLE_LOCKED;
               else if (beyond_relock) begin
                  if (db_expired) begin
                     state_d   = ST_SWEEP;
                     acq_start = 1'b1;
                  end else
                     state_d = ST_DB_WAIT;
               end
            end
            default: begin
               if (activity_i) begin
                  if (beyond_relock) begin
                     state_d   = ST_SWEEP;
                     acq_start = 1'b1;
                  end else
                     state_d = ST_PHASE_TRACK;
               end
            end
         endcase
      end
   end

   assign sweep_adv = (state_q == ST_SWEEP) && step_i;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         state_q <= ST_SWEEP;
      else
         state_q <= state_d;
   end

   assign flags      = state_flags(state_q);
   assign lol_o      = flags.lol;
   assign handover_o = flags.handover;

endmodule

// File: rtl/facq_supervisor_chk.sv
module facq_supervisor_chk #(
   parameter int ERR_W      = 16,
   parameter int SWEEP_W    = 12,
   parameter int LOCK_PPM   = 250,
   parameter int RELOCK_PPM = 1000
) (
   input logic               clk,
   input logic               por_n,
   input logic               soft_rst_i,
   input logic               step_i,
   input logic               activity_i,
   input logic [ERR_W-1:0]   ferr_i,
   input logic               lol_o,
   input logic               handover_o,
   input logic [SWEEP_W-1:0] sweep_o
);
   logic [ERR_W:0] mag;
   assign mag = ferr_i[ERR_W-1] ? ({1'b0, ~ferr_i} + (ERR_W+1)'(1)) : {1'b0, ferr_i};

   // R1: flags are exclusive
   p_flags_excl_r1: assert property (@(posedge clk) disable iff (!por_n)
      !(lol_o && handover_o));

   // R3: within an attempt the sweep only climbs by one or restarts at zero
   p_sweep_mono_r3: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> (sweep_o == $past(sweep_o)) ||
               (sweep_o == SWEEP_W'($past(sweep_o) + SWEEP_W'(1))) ||
               (sweep_o == '0));

   // R13: no strobe, no step
   p_sweep_hold_r13: assert property (@(posedge clk) disable iff (!por_n)
      (!step_i && !soft_rst_i) |=> (sweep_o == $past(sweep_o)) || (sweep_o == '0));

   // R2: handover out of the coarse loop only with a small error
   p_handover_window_r2: assert property (@(posedge clk) disable iff (!por_n)
      (lol_o && activity_i && !soft_rst_i && (mag > (ERR_W+1)'(LOCK_PPM))) |=> !handover_o);

   // R6: small error keeps lock while tracking
   p_keep_lock_r6: assert property (@(posedge clk) disable iff (!por_n)
      (handover_o && activity_i && !soft_rst_i && (mag <= (ERR_W+1)'(RELOCK_PPM))) |=> !lol_o);

   // R8: a quiet input never raises loss of lock
   p_quiet_no_lol_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!lol_o && !activity_i && !soft_rst_i) |=> !lol_o);

   // R12: soft reset restarts at zero in the coarse loop
   p_soft_restart_r12: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst_i |=> (lol_o && (sweep_o == '0)));

endmodule

bind facq_supervisor facq_supervisor_chk #(
   .ERR_W(ERR_W), .SWEEP_W(SWEEP_W), .LOCK_PPM(LOCK_PPM), .RELOCK_PPM(RELOCK_PPM)
) u_chk (
   .clk(clk), .por_n(por_n), .soft_rst_i(soft_rst_i), .step_i(step_i),
   .activity_i(activity_i), .ferr_i(ferr_i), .lol_o(lol_o),
   .handover_o(handover_o), .sweep_o(sweep_o)
);

// File: tb/sim_facq_supervisor.sv
module sim_facq_supervisor;
   localparam int EW   = 16;
   localparam int SW   = 4;
   localparam int DBL  = 40;
   localparam int DBS  = 8;
   localparam int SMAX = (1 << SW) - 1;
   localparam int PER_LONG  = ((DBL > SMAX + 1) ? DBL : SMAX + 1) + 1;
   localparam int PER_SHORT = ((DBS > SMAX + 1) ? DBS : SMAX + 1) + 1;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic soft_rst = 1'b0, tick = 1'b1, step = 1'b1, act = 1'b1;
   logic [EW-1:0] ferr = 16'd5000;
   logic cfg_we = 1'b0;
   logic [0:0] cfg_addr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic lol, ho;
   logic [SW-1:0] sweep;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   facq_supervisor #(.ERR_W(EW), .SWEEP_W(SW), .DB_LONG_TICKS(DBL),
                     .DB_SHORT_TICKS(DBS)) u0 (
      .clk(clk), .por_n(por_n), .soft_rst_i(soft_rst), .tick_i(tick), .step_i(step),
      .activity_i(act), .ferr_i(ferr), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
      .cfg_wdata_i(cfg_wdata), .lol_o(lol), .handover_o(ho), .sweep_o(sweep)
   );

   task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic soft_pulse();
      soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
   endtask

   task automatic cfg_write(input logic a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cyc(1); cfg_we = 1'b0;
   endtask

   // negedges from now until the sweep next falls back to zero
   task automatic to_restart(output int c);
      int prev;
      prev = int'(sweep);
      c = 0;
      for (int i = 0; i < 200; i++) begin
         cyc(1); c++;
         if (sweep == '0 && prev != 0) return;
         prev = int'(sweep);
      end
      c = -1;
   endtask

   task automatic measure_period(output int p);
      int dummy;
      to_restart(dummy);
      to_restart(p);
   endtask

   task automatic t_reset();
      cyc(2);
      check(lol == 1'b1 && ho == 1'b0, "R1 reset flags", {lol, ho}, 2);
      check(sweep == '0, "R3 reset sweep", sweep, 0);
      por_n = 1'b1;
      cyc(1);
   endtask

   task automatic t_long_period();
      int p;
      ferr = 16'd5000; act = 1'b1;
      measure_period(p);
      check(p == PER_LONG, "R4 R5 default long period", p, PER_LONG);
   endtask

   task automatic t_monotonic();
      int prev, bad;
      bad = 0;
      soft_pulse();
      prev = int'(sweep);
      for (int i = 0; i < 14; i++) begin
         cyc(1);
         if (int'(sweep) != prev + 1) bad++;
         prev = int'(sweep);
      end
      check(bad == 0, "R3 unit climb", bad, 0);
      cyc(4);
      check(sweep == SW'(SMAX) && lol, "R4 parked at top", sweep, SMAX);
   endtask

   task automatic t_lock_and_relock();
      int sw;
      soft_pulse(); cyc(2);
      ferr = 16'd251; cyc(1);
      check(lol == 1'b1, "R2 251 no handover", lol, 1);
      ferr = -16'sd250; cyc(1);
      check(ho == 1'b1 && lol == 1'b0, "R2 R1 handover at -250", {lol, ho}, 1);
      ferr = 16'd1000; cyc(2);
      check(lol == 1'b0, "R6 +1000 keeps lock", lol, 0);
      ferr = -16'sd1000; cyc(2);
      check(lol == 1'b0, "R6 -1000 keeps lock", lol, 0);
      sw = int'(sweep);
      ferr = 16'd1001; cyc(1);
      check(lol == 1'b1 && ho == 1'b0, "R7 1001 raises lol", {lol, ho}, 2);
      check(int'(sweep) == sw, "R7 sweep held in dead band", sweep, sw);
      cyc(10);
      check(int'(sweep) == sw, "R7 still held", sweep, sw);
      begin
         int c;
         to_restart(c);
         check(c > 0 && lol, "R7 restart after expiry", c, 1);
      end
      cyc(2);
      ferr = 16'd0; cyc(1);
      check(ho == 1'b1, "R2 relock", ho, 1);
      cyc(DBL + 5);
      ferr = -16'sd2000; cyc(1);
      check(sweep == '0 && lol, "R7 immediate restart after expiry", sweep, 0);
   endtask

   task automatic t_quiet();
      int bad;
      soft_pulse(); cyc(3);
      ferr = 16'd0; cyc(1);
      act = 1'b0; ferr = 16'd30000; bad = 0;
      for (int i = 0; i < 20; i++) begin
         cyc(1);
         if (lol) bad++;
      end
      check(bad == 0, "R8 no lol while quiet", bad, 0);
      check(ho == 1'b0, "R1 R8 holdover flags", ho, 0);
      act = 1'b1; cyc(1);
      check(sweep == '0 && lol, "R9 restart ignores dead band", sweep, 0);
      cyc(3);
      ferr = 16'd0; cyc(1);
      act = 1'b0; cyc(3);
      act = 1'b1; ferr = 16'd500; cyc(1);
      check(ho == 1'b1 && lol == 1'b0, "R9 resume tracking", {lol, ho}, 1);
   endtask

   task automatic t_config();
      int p;
      ferr = 16'd5000;
      cfg_write(1'b0, 8'h80); cfg_write(1'b1, 8'h40);
      soft_pulse(); measure_period(p);
      check(p == PER_SHORT, "R10 short selected", p, PER_SHORT);
      cfg_write(1'b1, 8'h41);
      soft_pulse(); measure_period(p);
      check(p == PER_LONG, "R10 wrong key keeps long", p, PER_LONG);
      cfg_write(1'b1, 8'h40); cfg_write(1'b0, 8'h7F);
      soft_pulse(); measure_period(p);
      check(p == PER_LONG, "R10 bit 7 clear keeps long", p, PER_LONG);
      cfg_write(1'b0, 8'h80);
      soft_pulse(); soft_pulse(); measure_period(p);
      check(p == PER_SHORT, "R11 config survives soft reset", p, PER_SHORT);
      por_n = 1'b0; cyc(2); por_n = 1'b1;
      measure_period(p);
      check(p == PER_LONG, "R11 power-on restores long", p, PER_LONG);
   endtask

   task automatic t_soft_mid_wait();
      int c;
      soft_pulse(); cyc(20);
      check(sweep == SW'(SMAX), "R4 waiting at top", sweep, SMAX);
      soft_pulse();
      check(sweep == '0 && lol, "R12 soft restart", sweep, 0);
      to_restart(c);
      check(c == PER_LONG, "R12 dead band reloaded", c, PER_LONG);
   endtask

   task automatic t_step_hold();
      int sw;
      soft_pulse(); cyc(3);
      step = 1'b0; sw = int'(sweep); cyc(5);
      check(int'(sweep) == sw && lol, "R13 no strobe holds sweep", sweep, sw);
      step = 1'b1; cyc(1);
      check(int'(sweep) == sw + 1, "R13 strobe resumes", sweep, sw + 1);
   endtask

   initial begin
      t_reset();
      t_long_period();
      t_monotonic();
      t_lock_and_relock();
      t_quiet();
      t_config();
      t_soft_mid_wait();
      t_step_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule